// File: doc/BRIEF.md
# Timestamped Sample Cluster Packer

This block sits between a 16-bit sample source and the memory that holds a capture. Each accepted sample is an event. Events are grouped into clusters of eight 16-bit words. Word 0 of a cluster is a timestamp and words 1 to 7 are seven consecutive events. Sixty-four clusters fill one 512-word (1024-byte) memory line. The timestamp counts accepted sample periods since the last start and wraps modulo 2^16. The first event of a cluster carries the timestamp value, and the next six events fall at that value plus one to plus six.

A start pulse clears the timestamp, the position counters and the trigger record, and opens capture. Capture closes on a stop pulse, or when the line counter reaches its all-ones value, which marks the buffer as full. Positions use a 24-bit code: the line index sits at bit 9 and up, and the event index within the line (0 to 447) sits in bits 8:0. The block keeps two positions. The stop position is the last event accepted. The trigger position is taken from the first trigger pulse after start. Both can be read as bytes through a select input, and a status byte reports capture, full and trigger state.

Top module: `ts_cluster_packer`

## Requirements
- R1: While reset is held, `wr_en_o` is 0, `status_o` is 0 and both positions are 0.
- R2: For the k-th accepted sample since start (k from 0), with e = k mod 448, the sample is written to line k/448 at word index 8*(e/7) + (e mod 7) + 1. A cluster's word 8*(e/7) holds k - (e mod 7), taken modulo 2^16.
- R3: Position code = (line index << 9) | event index. The event index is cluster*7 + slot. It runs 0 to 447 and then restarts at 0 as the line index steps by one.
- R4: A sample accepted at clock edge N appears on the write port after edge N+1. When it opens a cluster, the timestamp word appears after edge N. The port writes nothing else.
- R5: `stop_pos_o` holds the position of the last accepted event, or 0 if no event has been accepted since start.
- R6: The first trigger pulse during capture records the position of the event accepted in that cycle. If no event is accepted in that cycle, it records the position of the next event. Status bit 5 then reads 1.
- R7: Trigger pulses after the first one leave `trig_pos_o` unchanged until the next start.
- R8: An event that moves the line index to 2^LINE_W-1 ends capture. Status bit 1 is then set and bit 0 cleared, and later samples are neither written nor counted. The last event's write still completes.
- R9: A stop pulse ends capture. Samples after it are not written and do not move `stop_pos_o`. A sample or trigger that arrives in the same cycle as start or stop is ignored.
- R10: `pos_byte_o` returns trigger-position bytes 0, 1, 2 for `sel_i` 0, 1, 2 (least significant first). It returns stop-position bytes 0, 1, 2 for `sel_i` 3, 4, 5, and 0 for `sel_i` 6 and 7.
- R11: `status_o` bit 0 = capturing, bit 1 = full, bit 5 = trigger recorded; all other bits are 0.
- R12: A start after a finished capture clears the full flag, the trigger record, the timestamp and both positions, and writing begins again at line 0, word 0.
- R13: Accepted samples are at least two clocks apart; `smp_valid_i` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clear state and open capture |
| stop_i | input | 1 | Close capture |
| smp_valid_i | input | 1 | Sample strobe, one per sample period |
| smp_data_i | input | 16 | Sample value |
| trig_i | input | 1 | Trigger pulse |
| wr_en_o | output | 1 | Memory word write strobe |
| wr_line_o | output | LINE_W | Line address of the write |
| wr_word_o | output | 9 | Word index within the line |
| wr_data_o | output | 16 | Word to write |
| trig_pos_o | output | 24 | Recorded trigger position |
| stop_pos_o | output | 24 | Position of the last accepted event |
| sel_i | input | 3 | Position byte select |
| pos_byte_o | output | 8 | Selected position byte |
| status_o | output | 8 | Capture, full and trigger flags |

## Verification
The bench builds the packer with LINE_W = 2, so the buffer is full once three lines (1344 events) are stored. This puts the full stop, the discarding of later samples and the discarding of a late trigger inside a short run. The same setting also covers a line crossing at event 447 to 448 and the clusters before and after it. The default width of 15 would need more than fourteen million events to reach the full condition, so only the narrow build exercises that path.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int EVT_PER_CLU   = 7;
  localparam int CLU_PER_LINE  = 64;
  localparam int WORDS_PER_CLU = EVT_PER_CLU + 1;
  localparam int EVT_PER_LINE  = EVT_PER_CLU * CLU_PER_LINE;
  localparam int SLOT_W        = $clog2(EVT_PER_CLU);
  localparam int CLU_W         = $clog2(CLU_PER_LINE);
  localparam int EVT_W         = $clog2(EVT_PER_LINE);
  localparam int WORD_W        = $clog2(WORDS_PER_CLU * CLU_PER_LINE);
  localparam int DATA_W        = 16;
  localparam int POS_W         = 24;
  localparam int POS_LINE_W    = POS_W - EVT_W;

  // event index within a line from cluster and slot
  function automatic logic [EVT_W-1:0] evt_of(logic [CLU_W-1:0] clu, logic [SLOT_W-1:0] slot);
    return ({{(EVT_W-CLU_W){1'b0}}, clu} * EVT_W'(EVT_PER_CLU)) + {{(EVT_W-SLOT_W){1'b0}}, slot};
  endfunction

  // word index within a line: slot 0 of a cluster is the timestamp
  function automatic logic [WORD_W-1:0] word_of(logic [CLU_W-1:0] clu, logic [SLOT_W-1:0] slot,
                                                 logic is_ts);
    return is_ts ? {clu, 3'd0} : {clu, slot + 3'd1};
  endfunction

  // 24-bit position code: line above bit 9, event index below
  function automatic logic [POS_W-1:0] pos_of(logic [POS_LINE_W-1:0] line, logic [EVT_W-1:0] evt);
    return {line, evt};
  endfunction
endpackage

// File: rtl/tcp_seq_counter.sv
module tcp_seq_counter
  import tcp_pkg::*;
#(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              smp_valid_i,
  output logic              accept_o,
  output logic              cap_o,
  output logic              full_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CLU_W-1:0]  clu_o,
  output logic [EVT_W-1:0]  evt_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [LINE_W-1:0] FULL_LINE = '1;
  localparam logic [LINE_W-1:0] LAST_LINE = FULL_LINE - LINE_W'(1);

  logic              cap_q, full_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CLU_W-1:0]  clu_q;
  logic [EVT_W-1:0]  evt_q;
  logic [LINE_W-1:0] line_q;

  logic accept, slot_wrap, line_wrap, reach_full;
  assign accept     = smp_valid_i && cap_q && !start_i && !stop_i;
  assign slot_wrap  = slot_q == SLOT_W'(EVT_PER_CLU - 1);
  assign line_wrap  = slot_wrap && (clu_q == CLU_W'(CLU_PER_LINE - 1));
  assign reach_full = accept && line_wrap && (line_q == LAST_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0; full_q <= 1'b0;
      slot_q <= '0; clu_q <= '0; evt_q <= '0; line_q <= '0;
    end else if (start_i) begin
      cap_q <= 1'b1; full_q <= 1'b0;
      slot_q <= '0; clu_q <= '0; evt_q <= '0; line_q <= '0;
    end else if (stop_i) begin
      cap_q <= 1'b0;
    end else if (accept) begin
      if (!slot_wrap) begin
        slot_q <= slot_q + SLOT_W'(1);
        evt_q  <= evt_q + EVT_W'(1);
      end else if (!line_wrap) begin
        slot_q <= '0;
        clu_q  <= clu_q + CLU_W'(1);
        evt_q  <= evt_q + EVT_W'(1);
      end else begin
        slot_q <= '0;
        clu_q  <= '0;
        evt_q  <= '0;
        line_q <= line_q + LINE_W'(1);
      end
      if (reach_full) begin
        full_q <= 1'b1;
        cap_q  <= 1'b0;
      end
    end
  end

  assign accept_o = accept;
  assign cap_o    = cap_q;
  assign full_o   = full_q;
  assign slot_o   = slot_q;
  assign clu_o    = clu_q;
  assign evt_o    = evt_q;
  assign line_o   = line_q;

  AST_EVT_MATCHES_CLUSTER: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q == evt_of(clu_q, slot_q)); // R3
  AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> !smp_valid_i); // R13
  AST_FULL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !cap_q); // R8
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |-> line_q != FULL_LINE); // R8
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !cap_q); // R9
endmodule

// File: rtl/tcp_word_writer.sv
module tcp_word_writer
  import tcp_pkg::*;
#(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              accept_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CLU_W-1:0]  clu_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_en_o,
  output logic [LINE_W-1:0] wr_line_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [DATA_W-1:0] ts_q;
  logic              pend_q;
  logic [LINE_W-1:0] p_line_q;
  logic [WORD_W-1:0] p_word_q;
  logic [DATA_W-1:0] p_data_q;

  logic cluster_open;
  assign cluster_open = accept_i && (slot_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0; pend_q <= 1'b0;
      p_line_q <= '0; p_word_q <= '0; p_data_q <= '0;
      wr_en_o <= 1'b0; wr_line_o <= '0; wr_word_o <= '0; wr_data_o <= '0;
    end else begin
      if (start_i)       ts_q <= '0;
      else if (accept_i) ts_q <= ts_q + DATA_W'(1);

      if (pend_q) begin
        wr_en_o   <= 1'b1;
        wr_line_o <= p_line_q;
        wr_word_o <= p_word_q;
        wr_data_o <= p_data_q;
      end else if (cluster_open) begin
        wr_en_o   <= 1'b1;
        wr_line_o <= line_i;
        wr_word_o <= word_of(clu_i, slot_i, 1'b1);
        wr_data_o <= ts_q;
      end else begin
        wr_en_o <= 1'b0;
      end

      pend_q <= accept_i;
      if (accept_i) begin
        p_line_q <= line_i;
        p_word_q <= word_of(clu_i, slot_i, 1'b0);
        p_data_q <= data_i;
      end
    end
  end

  AST_TS_OPENS_CLUSTER: assert property (@(posedge clk) disable iff (!rst_n)
    cluster_open |=> wr_en_o && (wr_word_o[2:0] == 3'd0)); // R2
  AST_SAMPLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> ##1 (wr_en_o && wr_data_o == $past(data_i, 2))); // R4
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(accept_i) || $past(accept_i, 2))); // R4
endmodule

// File: rtl/tcp_pos_capture.sv
module tcp_pos_capture
  import tcp_pkg::*;
#(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cap_i,
  input  logic              accept_i,
  input  logic              trig_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [POS_W-1:0]  trig_pos_o,
  output logic [POS_W-1:0]  stop_pos_o,
  output logic              trig_seen_o
);
  logic [POS_W-1:0] trig_pos_q, stop_pos_q;
  logic             seen_q;

  logic [POS_W-1:0] cur_pos;
  logic             trig_take;
  assign cur_pos   = pos_of(POS_LINE_W'(line_i), evt_i);
  assign trig_take = trig_i && cap_i && !start_i && !stop_i && !seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_pos_q <= '0; stop_pos_q <= '0; seen_q <= 1'b0;
    end else if (start_i) begin
      trig_pos_q <= '0; stop_pos_q <= '0; seen_q <= 1'b0;
    end else begin
      if (trig_take) begin
        trig_pos_q <= cur_pos;
        seen_q     <= 1'b1;
      end
      if (accept_i) stop_pos_q <= cur_pos;
    end
  end

  assign trig_pos_o  = trig_pos_q;
  assign stop_pos_o  = stop_pos_q;
  assign trig_seen_o = seen_q;

  AST_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !start_i |=> $stable(trig_pos_q) && seen_q); // R7
  AST_STOP_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i && !start_i |=> $stable(stop_pos_q)); // R5
  AST_TRIG_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> $past(cap_i)); // R6
endmodule

// File: rtl/ts_cluster_packer.sv
module ts_cluster_packer
  import tcp_pkg::*;
#(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              smp_valid_i,
  input  logic [15:0]       smp_data_i,
  input  logic              trig_i,
  output logic              wr_en_o,
  output logic [LINE_W-1:0] wr_line_o,
  output logic [8:0]        wr_word_o,
  output logic [15:0]       wr_data_o,
  output logic [23:0]       trig_pos_o,
  output logic [23:0]       stop_pos_o,
  input  logic [2:0]        sel_i,
  output logic [7:0]        pos_byte_o,
  output logic [7:0]        status_o
);
  logic              accept, cap, full, trig_seen;
  logic [SLOT_W-1:0] slot;
  logic [CLU_W-1:0]  clu;
  logic [EVT_W-1:0]  evt;
  logic [LINE_W-1:0] line;

  tcp_seq_counter #(.LINE_W(LINE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .smp_valid_i(smp_valid_i), .accept_o(accept), .cap_o(cap), .full_o(full),
    .slot_o(slot), .clu_o(clu), .evt_o(evt), .line_o(line)
  );

  tcp_word_writer #(.LINE_W(LINE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_i(accept),
    .slot_i(slot), .clu_i(clu), .line_i(line), .data_i(smp_data_i),
    .wr_en_o(wr_en_o), .wr_line_o(wr_line_o), .wr_word_o(wr_word_o), .wr_data_o(wr_data_o)
  );

  tcp_pos_capture #(.LINE_W(LINE_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .cap_i(cap),
    .accept_i(accept), .trig_i(trig_i), .line_i(line), .evt_i(evt),
    .trig_pos_o(trig_pos_o), .stop_pos_o(stop_pos_o), .trig_seen_o(trig_seen)
  );

  always_comb begin
    case (sel_i)
      3'd0:    pos_byte_o = trig_pos_o[7:0];
      3'd1:    pos_byte_o = trig_pos_o[15:8];
      3'd2:    pos_byte_o = trig_pos_o[23:16];
      3'd3:    pos_byte_o = stop_pos_o[7:0];
      3'd4:    pos_byte_o = stop_pos_o[15:8];
      3'd5:    pos_byte_o = stop_pos_o[23:16];
      default: pos_byte_o = 8'h00;
    endcase
  end

  assign status_o = {2'b00, trig_seen, 3'b000, full, cap};

  AST_WRITE_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_line_o != '1); // R8
endmodule

// File: tb/ts_cluster_packer_test.sv
module ts_cluster_packer_test;
  localparam int CLK_P = 10;
  localparam int LW    = 2;
  // rows: samples, trigger sample A, trigger sample B, expected stop pos, expected trig pos
  localparam int VEC [5][5] = '{
    '{5,   2,   -1,  4,   2},
    '{7,   0,   5,   6,   0},
    '{8,   7,   -1,  7,   7},
    '{450, 447, 448, 513, 447},
    '{20,  -1,  -1,  19,  0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, smp_valid_i = 0, trig_i = 0;
  logic [15:0] smp_data_i = 0;
  logic [2:0]  sel_i = 0;
  logic        wr_en_o;
  logic [LW-1:0] wr_line_o;
  logic [8:0]  wr_word_o;
  logic [15:0] wr_data_o;
  logic [23:0] trig_pos_o, stop_pos_o;
  logic [7:0]  pos_byte_o, status_o;

  int checks = 0, fails = 0, wcount = 0;
  logic [15:0] mem [int];

  always #(CLK_P/2) clk = ~clk;

  ts_cluster_packer #(.LINE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .trig_i(trig_i),
    .wr_en_o(wr_en_o), .wr_line_o(wr_line_o), .wr_word_o(wr_word_o), .wr_data_o(wr_data_o),
    .trig_pos_o(trig_pos_o), .stop_pos_o(stop_pos_o), .sel_i(sel_i),
    .pos_byte_o(pos_byte_o), .status_o(status_o)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en_o) begin
      mem[int'(wr_line_o) * 512 + int'(wr_word_o)] = wr_data_o;
      wcount++;
    end
  end

  function automatic int pos_e(int i);
    return ((i / 448) << 9) | (i % 448);
  endfunction

  function automatic logic [15:0] dat(int i, int seed);
    return 16'(i * 40503 + seed);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mem_chk(int n, int seed, string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      int e = i % 448;
      int key = (i / 448) * 512 + (e / 7) * 8 + (e % 7) + 1;
      if (!mem.exists(key) || mem[key] !== dat(i, seed)) bad++;
      if ((e % 7) == 0) begin
        if (!mem.exists(key - 1) || mem[key - 1] !== 16'(i)) bad++;
      end
    end
    chk({tag, " R2 R3 words in place"}, bad, 0);
    chk({tag, " R4 write count"}, wcount, n + (n + 6) / 7);
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    mem.delete();
    wcount = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int i, int seed, bit tr);
    @(negedge clk) begin smp_valid_i = 1; smp_data_i = dat(i, seed); trig_i = tr; end
    @(negedge clk) begin smp_valid_i = 0; trig_i = 0; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 status", status_o, 0);
    chk("R1 wr_en", wr_en_o, 0);
    chk("R1 stop pos", stop_pos_o, 0);
    chk("R1 trig pos", trig_pos_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R5 R6 R7 R11
    for (int r = 0; r < 5; r++) begin
      do_start();
      chk("R11 capturing flag", status_o, 32'h01);
      for (int i = 0; i < VEC[r][0]; i++)
        send(i, r * 77, (i == VEC[r][1]) || (i == VEC[r][2]));
      do_stop();
      mem_chk(VEC[r][0], r * 77, "table");
      chk("R5 stop pos", stop_pos_o, VEC[r][3]);
      chk("R6 R7 trig pos", trig_pos_o, VEC[r][4]);
      chk("R11 status", status_o, (VEC[r][1] >= 0) ? 32'h20 : 32'h00);
      if (r == 3) begin
        logic [7:0] expb [8] = '{8'hBF, 8'h01, 8'h00, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00};
        for (int s = 0; s < 8; s++) begin
          sel_i = 3'(s);
          #1;
          chk("R10 position byte", pos_byte_o, expb[s]);
        end
      end
    end

    // R4 write timing
    do_start();
    @(negedge clk) begin smp_valid_i = 1; smp_data_i = 16'h1234; end
    @(negedge clk) smp_valid_i = 0;
    chk("R4 ts word strobe", wr_en_o, 1);
    chk("R4 ts word index", wr_word_o, 0);
    chk("R4 ts value", wr_data_o, 0);
    @(negedge clk) begin smp_valid_i = 1; smp_data_i = 16'h5678; end
    chk("R4 sample strobe", wr_en_o, 1);
    chk("R4 sample index", wr_word_o, 1);
    chk("R4 sample value", wr_data_o, 16'h1234);
    @(negedge clk) smp_valid_i = 0;
    chk("R4 no ts mid cluster", wr_en_o, 0);
    @(negedge clk);
    chk("R4 second sample index", wr_word_o, 2);
    chk("R4 second sample value", wr_data_o, 16'h5678);

    // R9 samples after stop are dropped
    do_stop();
    send(2, 0, 1'b1);
    send(3, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 no writes after stop", wcount, 3);
    chk("R9 stop pos unchanged", stop_pos_o, 1);
    chk("R9 trigger after stop ignored", status_o, 0);

    // R6 trigger between samples takes next event position
    do_start();
    for (int i = 0; i < 4; i++) send(i, 9, 1'b0);
    @(negedge clk) trig_i = 1;
    @(negedge clk) trig_i = 0;
    send(4, 9, 1'b0);
    send(5, 9, 1'b0);
    do_stop();
    chk("R6 trig between samples", trig_pos_o, 4);
    chk("R6 trig flag", status_o, 32'h20);

    // R8 full buffer
    do_start();
    for (int i = 0; i < 1400; i++) send(i, 3, i == 1345);
    repeat (3) @(negedge clk);
    chk("R8 status full", status_o, 32'h02);
    chk("R8 stop pos at end", stop_pos_o, (2 << 9) | 447);
    mem_chk(1344, 3, "R8 full");
    do_stop();

    // R12 restart after full
    do_start();
    for (int i = 0; i < 3; i++) send(i, 5, 1'b0);
    do_stop();
    chk("R12 status cleared", status_o, 0);
    chk("R12 stop pos", stop_pos_o, pos_e(2));
    chk("R12 trig pos cleared", trig_pos_o, 0);
    mem_chk(3, 5, "R12 restart");

    summary();
    $finish;
  end
endmodule